// File: doc/BRIEF.md
# Read-Mode ADC Handshake Controller

This block runs an 8-bit parallel analog-to-digital converter that times its own conversions. Its chip select is tied active permanently. To start a conversion the block pulls the converter's active-low read strobe low. The converter answers by pulling its active-low completion line low once the result sits in its output latch. The block then samples the data bus and the converter's active-low overflow output, and raises the read strobe again. That rising edge clears the completion line.

The completion line is asynchronous to the block clock, so it passes through a two-stage synchronizer before the state machine sees it. A cycle counter, sized from the clock frequency and a timeout in nanoseconds, ends a conversion that never completes and reports it with an error pulse. A new conversion starts only while the enable input is high and the synchronized completion line reads high again. This gives a continuous stream of samples, for example to feed a DAC directly.

Each result appears for one cycle on a valid strobe, together with the captured byte and an overflow flag.

Top module: `adcrd_ctrl`

## Requirements
- R1: The chip select output `adc_cs_n_o` is 0 in every cycle, including during and right after reset.
- R2: While reset is low and in the first cycle after it, `adc_rd_n_o` is 1 and `res_valid_o` and `tmo_err_o` are 0.
- R3: `adc_rd_n_o` falls only on an edge where the previous cycle had `run_i` high and the synchronized completion line high.
- R4: Once low, `adc_rd_n_o` stays low until the synchronized completion line reads low (then through one capture cycle) or the timeout expires; it is still low when the completion line falls.
- R5: The bus value and `res_over_o` = NOT `adc_ofl_n_i` are sampled one cycle after the synchronized completion line is first seen low. `res_valid_o` is a one-cycle pulse on the 4th rising clock edge after the completion line falls.
- R6: Each completed conversion yields exactly one `res_valid_o` pulse, and `adc_rd_n_o` is back at 1 in that same cycle.
- R7: If the completion line has not reached the state machine low within TMO_CYC = CLK_HZ*TMO_NS/1e9 cycles, the read strobe is low for exactly TMO_CYC cycles. `tmo_err_o` then pulses for one cycle in the cycle the strobe returns high, and no `res_valid_o` follows.
- R8: While the synchronized completion line stays low after a conversion, no new conversion starts; one starts after it returns high.
- R9: With `run_i` low, `adc_rd_n_o` stays 1 and no conversion starts.
- R10: `res_data_o` and `res_over_o` change only in a cycle where `res_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Enables starting new conversions |
| adc_cs_n_o | output | 1 | Converter chip select, held active (0) |
| adc_rd_n_o | output | 1 | Converter read strobe, active low, starts a conversion |
| adc_int_n_i | input | 1 | Converter completion line, active low, asynchronous |
| adc_db_i | input | DW | Converter data bus |
| adc_ofl_n_i | input | 1 | Converter overflow output, active low |
| res_valid_o | output | 1 | One-cycle strobe for a captured result |
| res_data_o | output | DW | Captured byte, held between results |
| res_over_o | output | 1 | Overflow flag captured with the byte (1 = input above range) |
| tmo_err_o | output | 1 | One-cycle pulse when a conversion times out |

## Verification
The bench builds the block with CLK_HZ = 20 MHz, TMO_NS = 1000 and DW = 8. This gives a timeout window of 20 cycles, so an unanswered conversion can be run to expiry and its exact strobe length measured in a few cycles. The converter model answers after latencies of 2 to 7 cycles, well inside that window, so normal and timed-out conversions are both covered. The model drives junk on the bus until it signals completion, and it can hold the completion line low after release. This exposes early sampling and a premature restart.

// File: rtl/adcrd_pkg.sv
// Package: shared state encoding and timing helpers for the read-mode
// ADC handshake controller.
// Assumes: clock frequency in Hz and timeout in ns fit a 64-bit product.
package adcrd_pkg;

    typedef enum logic [2:0] {
        S_IDLE       = 3'd0,
        S_ASSERT_RD  = 3'd1,
        S_WAIT_INT   = 3'd2,
        S_CAPTURE    = 3'd3,
        S_RELEASE_RD = 3'd4,
        S_GAP        = 3'd5
    } adcrd_state_e;

    // Number of clock cycles spanned by a time window, at least one.
    function automatic int tmo_cycles(input longint clk_hz, input longint win_ns);
        longint c;
        c = (clk_hz * win_ns) / 64'd1_000_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/adcrd_sync.sv
// Module: multi-stage synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; the input is a slow level, not a short pulse.
// Reset loads RST_VAL into every stage so the output starts idle.
module adcrd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/adcrd_tmo.sv
// Module: conversion timeout counter.
// Counts cycles while run_i is high and flags expiry in the LIMIT-th
// cycle of a run (count LIMIT-1). Clears whenever run_i is low.
// Assumes: LIMIT >= 1.
module adcrd_tmo #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Count while running, saturate at the last value, clear when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run_i) begin
            if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    assign expired_o = run_i && (cnt_q == LAST);

    AST_TMO_FRESH_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_i) |-> (cnt_q == '0)); // R7

endmodule

// File: rtl/adcrd_fsm.sv
// Module: handshake state machine for a self-timed read-mode converter.
// Drives the read strobe, waits for the synchronized completion line,
// samples the bus one cycle later and releases the strobe. A timeout
// releases the strobe without a result. A restart needs the completion
// line seen high again. All outputs are registered.
// Assumes: int_s_i is already synchronized to clk.
module adcrd_fsm
    import adcrd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          int_s_i,
    input  logic          tmo_exp_i,
    input  logic [DW-1:0] db_i,
    input  logic          ofl_n_i,
    output logic          rd_n_o,
    output logic          tmo_run_o,
    output logic          valid_o,
    output logic [DW-1:0] data_o,
    output logic          over_o,
    output logic          err_o
);

    adcrd_state_e st_q, st_nxt;
    logic         rd_n_q, valid_q, over_q, err_q;
    logic [DW-1:0] data_q;
    logic         rd_low_nxt;

    // Next-state decision for the handshake sequence.
    always_comb begin
        st_nxt = st_q;
        case (st_q)
            S_IDLE:       if (run_i && int_s_i) st_nxt = S_ASSERT_RD;
            S_ASSERT_RD:  st_nxt = S_WAIT_INT;
            S_WAIT_INT: begin
                if (!int_s_i)       st_nxt = S_CAPTURE;
                else if (tmo_exp_i) st_nxt = S_RELEASE_RD;
            end
            S_CAPTURE:    st_nxt = S_RELEASE_RD;
            S_RELEASE_RD: st_nxt = S_GAP;
            S_GAP:        st_nxt = S_IDLE;
            default:      st_nxt = S_IDLE;
        endcase
    end

    assign rd_low_nxt = (st_nxt == S_ASSERT_RD) || (st_nxt == S_WAIT_INT)
                     || (st_nxt == S_CAPTURE);

    // State register and registered read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            rd_n_q <= 1'b1;
        end else begin
            st_q   <= st_nxt;
            rd_n_q <= !rd_low_nxt;
        end
    end

    // Result capture, valid strobe and timeout error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
            over_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= (st_q == S_CAPTURE);
            err_q   <= (st_q == S_WAIT_INT) && int_s_i && tmo_exp_i;
            if (st_q == S_CAPTURE) begin
                data_q <= db_i;
                over_q <= !ofl_n_i;
            end
        end
    end

    assign tmo_run_o = (st_q == S_ASSERT_RD) || (st_q == S_WAIT_INT);
    assign rd_n_o    = rd_n_q;
    assign valid_o   = valid_q;
    assign data_o    = data_q;
    assign over_o    = over_q;
    assign err_o     = err_q;

    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n_q) |-> $past(run_i && int_s_i)); // R3
    AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n_q) |-> $past(!int_s_i || tmo_exp_i)); // R4
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q); // R5
    AST_VALID_WITH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> rd_n_q); // R6
    AST_TMO_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (!valid_q && rd_n_q)); // R7
    AST_NO_RESTART_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && !int_s_i) |=> rd_n_q); // R8
    AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && !run_i) |=> rd_n_q); // R9
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> ($stable(data_q) && $stable(over_q))); // R10

endmodule

// File: rtl/adcrd_ctrl.sv
// Module: top of the read-mode ADC handshake controller.
// Ties chip select active, synchronizes the completion line, sizes the
// timeout from CLK_HZ and TMO_NS, and wires the state machine to the
// converter pins and the result outputs.
// Assumes: the converter completes well inside TMO_NS.
module adcrd_ctrl #(
    parameter longint CLK_HZ    = 100_000_000,
    parameter longint TMO_NS    = 1000,
    parameter int     DW        = 8,
    parameter int     SYNC_STG  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    output logic          adc_cs_n_o,
    output logic          adc_rd_n_o,
    input  logic          adc_int_n_i,
    input  logic [DW-1:0] adc_db_i,
    input  logic          adc_ofl_n_i,
    output logic          res_valid_o,
    output logic [DW-1:0] res_data_o,
    output logic          res_over_o,
    output logic          tmo_err_o
);

    localparam int TMO_CYC = adcrd_pkg::tmo_cycles(CLK_HZ, TMO_NS);

    logic int_s;
    logic tmo_run;
    logic tmo_exp;

    assign adc_cs_n_o = 1'b0;

    adcrd_sync #(
        .STAGES  (SYNC_STG),
        .RST_VAL (1'b1)
    ) u_int_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (adc_int_n_i),
        .q_o   (int_s)
    );

    adcrd_tmo #(
        .LIMIT (TMO_CYC)
    ) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (tmo_run),
        .expired_o (tmo_exp)
    );

    adcrd_fsm #(
        .DW (DW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_i),
        .int_s_i   (int_s),
        .tmo_exp_i (tmo_exp),
        .db_i      (adc_db_i),
        .ofl_n_i   (adc_ofl_n_i),
        .rd_n_o    (adc_rd_n_o),
        .tmo_run_o (tmo_run),
        .valid_o   (res_valid_o),
        .data_o    (res_data_o),
        .over_o    (res_over_o),
        .err_o     (tmo_err_o)
    );

endmodule

// File: tb/adcrd_ctrl_tb_top.sv
// Bench: scoreboard test of the read-mode ADC handshake controller with
// a behavioural converter model.
module adcrd_ctrl_tb_top;

    localparam longint CLK_HZ  = 20_000_000;
    localparam longint TMO_NS  = 1000;
    localparam int     DW      = 8;
    localparam int     TMO_CYC = 20;   // 20 MHz * 1000 ns

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          cs_n, rd_n;
    logic          int_n = 1'b1;
    logic [DW-1:0] db = 8'hC3;
    logic          ofl_n = 1'b1;
    logic          valid;
    logic [DW-1:0] data;
    logic          over;
    logic          err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int falls  = 0;
    int t_int  = 0;
    logic rd_at_int = 1'b1;

    bit mute  = 1'b0;
    bit stuck = 1'b0;
    int lat   = 3;

    logic [8:0] adc_q[$];   // {ofl_n, byte} the model returns
    logic [8:0] exp_q[$];   // {over, byte} the design must report
    logic [8:0] item;

    adcrd_ctrl #(
        .CLK_HZ (CLK_HZ),
        .TMO_NS (TMO_NS),
        .DW     (DW)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .adc_cs_n_o  (cs_n),
        .adc_rd_n_o  (rd_n),
        .adc_int_n_i (int_n),
        .adc_db_i    (db),
        .adc_ofl_n_i (ofl_n),
        .res_valid_o (valid),
        .res_data_o  (data),
        .res_over_o  (over),
        .tmo_err_o   (err)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (cyc > 50000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<50000", cyc);
            summary();
            $finish;
        end
    end

    // Converter model: conversion starts on the falling read strobe.
    always @(negedge rd_n) begin
        falls++;
        if (!mute && adc_q.size() > 0) begin
            item = adc_q.pop_front();
            repeat (lat) @(posedge clk);
            #2;
            db        = item[7:0];
            ofl_n     = item[8];
            int_n     = 1'b0;
            t_int     = cyc;
            rd_at_int = rd_n;
        end
    end

    // Converter model: rising read strobe clears completion, bus goes to junk.
    always @(posedge rd_n) begin
        #1;
        if (!stuck) int_n = 1'b1;
        db    = db ^ 8'h96;
        ofl_n = 1'b1;
    end

    // Monitor: pop expected results and compare as they appear.
    always @(negedge clk) begin
        if (rst_n && valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected result", {23'd0, over, data}, 32'h0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check(data === e[7:0], "R5 data", data, e[7:0]);
                check(over === e[8], "R5 overflow", over, e[8]);
                check(cyc - t_int == 4, "R5 valid latency", cyc - t_int, 4);
                check(rd_n === 1'b1, "R6 strobe released with valid", rd_n, 1);
                check(rd_at_int === 1'b0, "R4 strobe low at completion", rd_at_int, 0);
            end
        end
        if (rst_n) begin
            if (cs_n !== 1'b0) check(1'b0, "R1 chip select", cs_n, 0);
        end
    end

    task automatic push(input logic [7:0] d, input logic of_n);
        adc_q.push_back({of_n, d});
        exp_q.push_back({~of_n, d});
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic one_conv(input logic [7:0] d, input logic of_n, input int l);
        lat = l;
        push(d, of_n);
        @(negedge clk);
        run = 1'b1;
        @(negedge rd_n);
        @(negedge clk);
        run = 1'b0;
        drain();
        repeat (6) @(negedge clk);
    endtask

    initial begin
        int f0;
        int n;
        logic [7:0] held;
        logic       held_o;

        // Reset state (R1, R2)
        repeat (4) @(negedge clk);
        check(rd_n === 1'b1, "R2 strobe in reset", rd_n, 1);
        check(valid === 1'b0, "R2 valid in reset", valid, 0);
        check(err === 1'b0, "R2 error in reset", err, 0);
        check(cs_n === 1'b0, "R1 chip select in reset", cs_n, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_n === 1'b1 && valid === 1'b0 && err === 1'b0,
              "R2 first cycle after reset", {rd_n, valid, err}, 3'b100);

        // Single conversions, with and without overflow (R4, R5, R6)
        one_conv(8'h5A, 1'b1, 3);
        one_conv(8'hFF, 1'b0, 7);
        one_conv(8'h01, 1'b1, 2);

        // Back-to-back stream with run held high (R5, R6)
        f0 = falls;
        lat = 2;
        push(8'h00, 1'b1);
        push(8'h80, 1'b0);
        push(8'h7E, 1'b1);
        push(8'hA5, 1'b0);
        @(negedge clk);
        run = 1'b1;
        drain();
        run = 1'b0;
        repeat (8) @(negedge clk);
        check(falls - f0 == 4, "R6 one strobe per result", falls - f0, 4);

        // Outputs hold while bus changes (R10)
        held   = data;
        held_o = over;
        db = 8'h3C;
        repeat (10) @(negedge clk);
        check(data === held && over === held_o, "R10 result held",
              {over, data}, {held_o, held});

        // Run low: no conversion (R9, R3)
        f0 = falls;
        repeat (30) @(negedge clk);
        check(falls == f0 && rd_n === 1'b1, "R9 R3 no start without run",
              falls - f0, 0);

        // Timeout (R7)
        mute = 1'b1;
        @(negedge clk);
        run = 1'b1;
        @(negedge rd_n);
        run = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            if (rd_n === 1'b0) n++;
        end while (rd_n === 1'b0);
        check(n == TMO_CYC, "R7 strobe length on timeout", n, TMO_CYC);
        check(err === 1'b1, "R7 error with release", err, 1);
        @(negedge clk);
        check(err === 1'b0, "R7 error is a pulse", err, 0);
        check(exp_q.size() == 0 && valid === 1'b0, "R7 no result on timeout", valid, 0);
        mute = 1'b0;
        repeat (6) @(negedge clk);

        // Completion line stuck low after release (R8, R3)
        stuck = 1'b1;
        lat = 2;
        push(8'h11, 1'b1);
        push(8'h22, 1'b0);
        @(negedge clk);
        run = 1'b1;
        while (exp_q.size() != 1) @(negedge clk);
        f0 = falls;
        repeat (15) @(negedge clk);
        check(falls == f0 && rd_n === 1'b1, "R8 R3 no restart while line low",
              falls - f0, 0);
        stuck = 1'b0;
        int_n = 1'b1;
        drain();
        run = 1'b0;
        repeat (6) @(negedge clk);
        check(falls == f0 + 1, "R8 restart after line high", falls - f0, 1);

        summary();
        $finish;
    end

endmodule